// File: doc/BRIEF.md
# Multi-phase pulse-width coincidence detector

This block decides whether two asynchronous single-bit events arrived close enough together to count as coincident. It takes the exclusive-OR of the two events and measures how long that mismatch pulse stays high. The pulse width can be shorter than one clock period. To resolve it, the block uses N copies of one base clock, each delayed by a further T/N. Every copy samples the mismatch through its own synchronizer flop and feeds a sticky set-only flag.

The number of raised flags, S, is the width in units of T/N. A width of T or more gives S = N. The base-clock controller notices the first raised flag and waits one period so that every phase has had its chance to sample. It then latches S and compares it against two programmable thresholds. When the low threshold is less than S and S is less than the high threshold, it pulses a coincidence strobe. Each strobe advances a saturating counter. The controller then clears all flags and re-arms.

The controller spends three base cycles on one detection: evaluate, report, clear. Events arriving in those cycles are discarded. Phase 0 of the clock vector is the base clock. The phase clocks are generated outside the block.

Top module: `coinc_width_detector`

## Requirements
- R1: The reported count S equals the number of phase-clock rising edges that fall while the exclusive-OR of the two events is high. Phase k rises k·T/N after the base clock.
- R2: `phase_count_o` takes the new S one base edge after the evaluate cycle. It holds that value until the next detection, including detections that are not coincident.
- R3: `coinc_stb_o` is high for exactly one base cycle after a detection, and only when `lo_thr_i` < S < `hi_thr_i`, both comparisons strict and unsigned.
- R4: `coinc_cnt_o` rises by exactly one on the base edge that ends each strobe cycle, and at no other time.
- R5: A mismatch pulse lasting one base period or longer reports S = N.
- R6: Mismatch activity during the evaluate, report and clear cycles that follow a detection has no effect on S, on the strobe or on the counter.
- R7: After the clear cycle, every flag is cleared, so the next detection reports only its own width.
- R8: The counter saturates at its all-ones value and holds there.
- R9: While `rst_ni` is low at a base edge, the counter, the reported count and the strobe return to zero.
- R10: Events that change together, so that their exclusive-OR never rises, produce no detection: no strobe, and the reported count and the counter stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| phase_clk_i | input | N | Phase clocks; bit k is the base clock delayed by k·T/N, bit 0 is the base clock |
| rst_ni | input | 1 | Synchronous active-low reset, sampled by every phase clock |
| ev_a_i | input | 1 | First event input, asynchronous |
| ev_b_i | input | 1 | Second event input, asynchronous |
| lo_thr_i | input | CW | Lower phase-count threshold (exclusive), held static |
| hi_thr_i | input | CW | Upper phase-count threshold (exclusive), held static |
| phase_count_o | output | CW | Phase count S of the most recent detection |
| coinc_stb_o | output | 1 | One-cycle coincidence strobe |
| coinc_cnt_o | output | CNT_W | Saturating coincidence counter |

## Verification
The hardest situation to create is mismatch activity inside the three blind cycles. The evaluate cycle is hardest of all. There, a late pulse reaches some flags after S has been latched, and those flags must be wiped rather than carried into a phantom second detection. The bench reaches it with a timed sequence placed sub-period against the base clock. One event pair makes a genuine pulse. Both events are then toggled apart again during the evaluate, report and clear cycles. Afterwards the bench confirms that only one strobe occurred and that a fresh pulse reports its own width.

// File: rtl/cd_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the coincidence detector.
package cd_pkg;
    // Controller phases of one detection.
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_EVAL  = 2'd1,
        ST_SHOW  = 2'd2,
        ST_WIPE  = 2'd3
    } cd_state_t;
endpackage

// File: rtl/cd_phase_lane.sv
`timescale 1ns/1ps
// Module: cd_phase_lane
// One sampling lane. It synchronizes the mismatch signal on its own phase
// clock and latches it into a sticky flag.
// Assumes: wipe_i and rst_ni are stable around phase_clk edges. Wipe
// empties the synchronizer as well, so a sample taken during the wipe
// cannot raise the flag afterwards.
module cd_phase_lane (
    input  logic phase_clk,
    input  logic rst_ni,
    input  logic mismatch_i,
    input  logic wipe_i,
    output logic flag_o
);
    logic sync_q;
    logic flag_q;

    // Synchronizer flop in front of the sticky flag.
    always_ff @(posedge phase_clk) begin
        if (!rst_ni || wipe_i) sync_q <= 1'b0;
        else                   sync_q <= mismatch_i;
    end

    // Set-only flag, cleared by reset or wipe.
    always_ff @(posedge phase_clk) begin
        if (!rst_ni || wipe_i) flag_q <= 1'b0;
        else if (sync_q)       flag_q <= 1'b1;
    end

    assign flag_o = flag_q;

    // R7: a wipe leaves the flag low on the following phase edge.
    a_r7_wipe_clears: assert property (@(posedge phase_clk) disable iff (!rst_ni)
        wipe_i |=> !flag_o);
    // R1: a raised flag stays raised until a wipe.
    a_r1_flag_sticky: assert property (@(posedge phase_clk) disable iff (!rst_ni)
        (flag_o && !wipe_i) |=> flag_o);
endmodule

// File: rtl/cd_ones_count.sv
`timescale 1ns/1ps
// Module: cd_ones_count
// Counts the raised flags across all lanes.
// Assumes: CW is wide enough to hold N.
module cd_ones_count #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  flags_i,
    output logic [CW-1:0] ones_o
);
    // Sum of set bits.
    always_comb begin
        ones_o = '0;
        for (int i = 0; i < N; i++) begin
            ones_o = ones_o + CW'(flags_i[i]);
        end
    end
endmodule

// File: rtl/cd_ctrl.sv
`timescale 1ns/1ps
// Module: cd_ctrl
// Base-clock controller. It waits for any raised flag, lets every phase
// sample for one more period, latches S and compares it with the window.
// It then strobes, counts and wipes the lanes before re-arming.
// Assumes: the thresholds are static while a detection is in progress.
module cd_ctrl
    import cd_pkg::*;
#(
    parameter int CW    = 4,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_ni,
    input  logic [CW-1:0]    ones_i,
    input  logic [CW-1:0]    lo_thr_i,
    input  logic [CW-1:0]    hi_thr_i,
    output logic             wipe_o,
    output logic [CW-1:0]    phase_count_o,
    output logic             stb_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    cd_state_t     state_q, state_d;
    logic [CW-1:0] s_q;
    logic          stb_q;
    logic [CNT_W-1:0] cnt_q;
    logic          past_ok_q;

    // Next-state choice for the detection sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (ones_i != '0) state_d = ST_EVAL;
            ST_EVAL:  state_d = ST_SHOW;
            ST_SHOW:  state_d = ST_WIPE;
            ST_WIPE:  state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_ni) state_q <= ST_ARMED;
        else         state_q <= state_d;
    end

    // Latch S and decide coincidence at the end of the evaluate cycle.
    always_ff @(posedge clk) begin
        if (!rst_ni) begin
            s_q   <= '0;
            stb_q <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (state_q == ST_EVAL) begin
                s_q   <= ones_i;
                stb_q <= (ones_i > lo_thr_i) && (ones_i < hi_thr_i);
            end
        end
    end

    // Saturating coincidence counter.
    always_ff @(posedge clk) begin
        if (!rst_ni)                       cnt_q <= '0;
        else if (stb_q && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    // Marks that $past values come from after reset.
    always_ff @(posedge clk) begin
        if (!rst_ni) past_ok_q <= 1'b0;
        else         past_ok_q <= 1'b1;
    end

    assign wipe_o        = (state_q == ST_WIPE);
    assign phase_count_o = s_q;
    assign stb_o         = stb_q;
    assign cnt_o         = cnt_q;

    // R3: the strobe lasts a single base cycle.
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_ni)
        stb_o |=> !stb_o);
    // R4: the counter moves only by one, and only after a strobe.
    a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_ni)
        (past_ok_q && cnt_o != $past(cnt_o)) |-> ($past(stb_o) && cnt_o == $past(cnt_o) + 1'b1));
    // R8: once at its maximum, the counter stays there.
    a_r8_cnt_hold_at_max: assert property (@(posedge clk) disable iff (!rst_ni)
        (past_ok_q && $past(cnt_o) == CNT_MAX) |-> cnt_o == CNT_MAX);
    // R2: the reported count changes only on leaving the evaluate cycle.
    a_r2_count_stable: assert property (@(posedge clk) disable iff (!rst_ni)
        (past_ok_q && phase_count_o != $past(phase_count_o)) |-> $past(state_q) == ST_EVAL);
    // R6: the wipe cycle is always preceded by the report cycle.
    a_r6_wipe_after_show: assert property (@(posedge clk) disable iff (!rst_ni)
        wipe_o |-> (past_ok_q && $past(state_q) == ST_SHOW));
endmodule

// File: rtl/coinc_width_detector.sv
`timescale 1ns/1ps
// Module: coinc_width_detector
// Top level. It forms the event mismatch, samples it in N phase lanes,
// counts the raised flags and runs the base-clock controller.
// Assumes: phase_clk_i[0] is the base clock and phase k lags it by k*T/N.
module coinc_width_detector #(
    parameter int N     = 8,
    parameter int CNT_W = 32,
    localparam int CW   = $clog2(N + 1)
) (
    input  logic [N-1:0]     phase_clk_i,
    input  logic             rst_ni,
    input  logic             ev_a_i,
    input  logic             ev_b_i,
    input  logic [CW-1:0]    lo_thr_i,
    input  logic [CW-1:0]    hi_thr_i,
    output logic [CW-1:0]    phase_count_o,
    output logic             coinc_stb_o,
    output logic [CNT_W-1:0] coinc_cnt_o
);
    logic          mismatch;
    logic          wipe;
    logic [N-1:0]  flags;
    logic [CW-1:0] ones;

    assign mismatch = ev_a_i ^ ev_b_i;

    // One sampling lane per phase clock.
    for (genvar k = 0; k < N; k++) begin : g_lane
        cd_phase_lane u_lane (
            .phase_clk  (phase_clk_i[k]),
            .rst_ni     (rst_ni),
            .mismatch_i (mismatch),
            .wipe_i     (wipe),
            .flag_o     (flags[k])
        );
    end

    cd_ones_count #(.N(N), .CW(CW)) u_ones (
        .flags_i (flags),
        .ones_o  (ones)
    );

    cd_ctrl #(.CW(CW), .CNT_W(CNT_W)) u_ctrl (
        .clk           (phase_clk_i[0]),
        .rst_ni        (rst_ni),
        .ones_i        (ones),
        .lo_thr_i      (lo_thr_i),
        .hi_thr_i      (hi_thr_i),
        .wipe_o        (wipe),
        .phase_count_o (phase_count_o),
        .stb_o         (coinc_stb_o),
        .cnt_o         (coinc_cnt_o)
    );
endmodule

// File: tb/coinc_width_detector_tb.sv
`timescale 1ns/1ps
module coinc_width_detector_tb;
    localparam int N     = 8;
    localparam int CW    = 4;
    localparam int CNT_W = 4;
    localparam int CMAX  = 15;

    logic          clk = 1'b0;
    logic [N-1:0]  ph;
    logic          rst_n = 1'b0;
    logic          ev_a = 1'b0, ev_b = 1'b0;
    logic [CW-1:0] lo = '0, hi = '0;
    logic [CW-1:0] pcount;
    logic          stb;
    logic [CNT_W-1:0] cnt;

    int n_chk = 0, n_fail = 0, n_stb = 0;
    int exp_cnt = 0, exp_s = 0;

    always #2 clk = ~clk;
    assign ph[0] = clk;
    for (genvar k = 1; k < N; k++) begin : g_ph
        logic pc = 1'b0;
        initial begin
            #(0.5 * k);
            forever #2 pc = ~pc;
        end
        assign ph[k] = pc;
    end

    coinc_width_detector #(.N(N), .CNT_W(CNT_W)) u_dut (
        .phase_clk_i(ph), .rst_ni(rst_n), .ev_a_i(ev_a), .ev_b_i(ev_b),
        .lo_thr_i(lo), .hi_thr_i(hi), .phase_count_o(pcount),
        .coinc_stb_o(stb), .coinc_cnt_o(cnt));

    always @(negedge clk) if (rst_n && stb) n_stb++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Mismatch of m half-ns steps starting 0.25 ns after a base edge, then
    // checks of S, strobe and counter at fixed offsets from that edge.
    task automatic pulse_and_check(input int m, input int l, input int h,
                                   input int es, input bit det, input bit hit);
        int s0;
        s0 = n_stb;
        lo = CW'(l); hi = CW'(h);
        @(posedge clk);
        #0.25 ev_a = 1'b1;
        if (m > 0) #(0.5 * m);
        ev_b = 1'b1;
        #(5.75 - 0.5 * m);
        ev_a = 1'b0; ev_b = 1'b0;
        #7;  // base edge + 13
        if (det) exp_s = es;
        check(pcount == CW'(exp_s), det ? "R1 phase count" : "R10 count unchanged", pcount, exp_s);
        check(stb == hit, "R3 strobe window", stb, hit);
        #4;  // base edge + 17
        if (hit && exp_cnt < CMAX) exp_cnt++;
        check(cnt == CNT_W'(exp_cnt), "R4 counter step", cnt, exp_cnt);
        check(n_stb - s0 == int'(hit), "R3 strobe count", n_stb - s0, hit);
        #8;
    endtask

    // Fields: m, lo, hi, expected S, {det, hit}
    localparam logic [39:0] VEC [12] = '{
        {8'd1,  8'd2, 8'd6, 8'd1, 8'b10},
        {8'd2,  8'd2, 8'd6, 8'd2, 8'b10},
        {8'd3,  8'd2, 8'd6, 8'd3, 8'b11},
        {8'd5,  8'd2, 8'd6, 8'd5, 8'b11},
        {8'd6,  8'd2, 8'd6, 8'd6, 8'b10},
        {8'd8,  8'd2, 8'd6, 8'd8, 8'b10},
        {8'd10, 8'd2, 8'd6, 8'd8, 8'b10},
        {8'd1,  8'd0, 8'd2, 8'd1, 8'b11},
        {8'd7,  8'd6, 8'd8, 8'd7, 8'b11},
        {8'd8,  8'd7, 8'd9, 8'd8, 8'b11},
        {8'd4,  8'd4, 8'd4, 8'd4, 8'b10},
        {8'd0,  8'd0, 8'd9, 8'd0, 8'b00}
    };

    initial begin
        #0.1;
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        check(cnt == 0 && pcount == 0 && stb == 0, "R9 reset state", cnt, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R1 R3 R5 R10: table of widths and windows
        for (int i = 0; i < 12; i++) begin
            pulse_and_check(int'(VEC[i][39:32]), int'(VEC[i][31:24]), int'(VEC[i][23:16]),
                            int'(VEC[i][15:8]), VEC[i][1], VEC[i][0]);
        end

        // R6: mismatch activity in evaluate, report and clear cycles
        begin
            int s0;
            s0 = n_stb;
            lo = 4'd2; hi = 4'd6;
            @(posedge clk);
            #0.25 ev_a = 1'b1;
            #1.5  ev_b = 1'b1;
            #6.5  ev_a = 1'b0;   // +8.25, evaluate cycle
            #1.5  ev_b = 1'b0;
            #2.5  ev_a = 1'b1;   // +12.25, report cycle
            #0.75;
            exp_s = 3;
            check(pcount == 4'd3, "R6 S unaffected", pcount, 3);
            check(stb == 1'b1, "R6 strobe", stb, 1);
            #0.25 ev_b = 1'b1;
            #3.0  ev_a = 1'b0;   // +16.25, clear cycle
            #0.75;
            exp_cnt++;
            check(cnt == CNT_W'(exp_cnt), "R6 counter", cnt, exp_cnt);
            #0.25 ev_b = 1'b0;
            #30;
            check(n_stb - s0 == 1, "R6 single strobe", n_stb - s0, 1);
            check(pcount == 4'd3, "R6 no phantom detection", pcount, 3);
            check(cnt == CNT_W'(exp_cnt), "R6 counter held", cnt, exp_cnt);
        end

        // R7: fresh measurement after the wipe
        pulse_and_check(2, 0, 9, 2, 1'b1, 1'b1);

        // R8: saturation
        for (int i = 0; i < 10; i++) pulse_and_check(4, 0, 9, 4, 1'b1, 1'b1);
        check(cnt == CNT_W'(CMAX), "R8 saturated", cnt, CMAX);

        // R9: reset during operation
        @(posedge clk);
        #1 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check(cnt == 0, "R9 counter cleared", cnt, 0);
        check(pcount == 0, "R9 count cleared", pcount, 0);
        check(stb == 0, "R9 strobe low", stb, 0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule